// File: doc/BRIEF.md
# Converter Serial Port Emulator

This block models the device side of a delta-sigma converter's serial port in external-clock mode. It repeats three states: `ST_CONVERT`, where a programmable cycle counter stands in for the conversion; `ST_SLEEP`, where a finished result waits for the host; and `ST_OUTPUT`, where a 32-bit status-prefixed frame is shifted out while a configuration command is captured from the host. Select, serial clock and serial data-in are sampled on the block's own system clock, and edges are found by comparing each sample with the previous one.

The named transitions are: `CONV_DONE` (`ST_CONVERT` to `ST_SLEEP`, when the cycle counter expires and the parallel result word is latched), `HOST_CLOCK` (`ST_SLEEP` to `ST_OUTPUT`, on the first serial-clock rising edge with select low), `FRAME_DONE` (`ST_OUTPUT` to `ST_CONVERT`, on the 32nd serial-clock falling edge) and `HOST_ABORT` (`ST_OUTPUT` to `ST_CONVERT`, when select rises before the frame is finished). Outside `ST_OUTPUT`, with select low, the data line shows a live end-of-conversion flag.

The captured command selects the input channel pair, an oversampling code and a double-speed flag. These fields are presented on configuration outputs. They change only when a frame ends and the command in it was complete and enabled.

Top module: `adc_if`

## Requirements
- R1: After reset the block is in `ST_CONVERT` and the configuration is single-ended flag 0, channel address 000 (positive input CH0, negative input CH1), oversampling code 4'b0011 (ratio 256) and double-speed flag 0.
- R2: While `cs_n` is high, `sdo_oe` is 0 and serial-clock edges cause no state change.
- R3: With `cs_n` low, `sdo` is 1 throughout `ST_CONVERT` and 0 throughout `ST_SLEEP`. A conversion lasts exactly `CONV_CYCLES` system clock cycles.
- R4: `ST_SLEEP` is left only on a serial-clock rising edge seen with `cs_n` low, which enters `ST_OUTPUT`.
- R5: The frame is `{1'b0, 1'b0, conv_data}`, sent MSB first, where `conv_data` is {sign (1 = positive), 24-bit result, 5 sub-LSBs}.
- R6: In `ST_OUTPUT`, `sdo` changes only after serial-clock falling edges. Before the first rising edge it shows frame bit 31, and after falling edge k (k = 1..31) it shows frame bit 31-k.
- R7: The 32nd falling edge returns the block to `ST_CONVERT`, so `sdo` goes to 1 and a full new conversion follows.
- R8: A rising edge on `cs_n` in `ST_OUTPUT` aborts the frame and starts a full new conversion.
- R9: The first 12 `sdi` bits are sampled on rising edges in the order 1, 0, enable, single-ended, address[2:0], oversampling[3:0], double-speed. They are applied at `FRAME_DONE` or `HOST_ABORT` when enable is 1 and all 12 were captured.
- R10: A frame whose enable bit is 0, or which ends with fewer than 12 `sdi` bits captured, leaves the configuration unchanged.
- R11: `conv_data` is latched at `CONV_DONE`. Changes after that point do not alter the frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Host serial clock |
| sdi | input | 1 | Host serial command data |
| conv_data | input | 30 | Result word: sign, 24-bit result, 5 sub-LSBs |
| sdo | output | 1 | Serial data or end-of-conversion flag |
| sdo_oe | output | 1 | Output enable for the tri-state `sdo` driver |
| cfg_sgl | output | 1 | Applied single-ended flag |
| cfg_addr | output | 3 | Applied channel address |
| cfg_osr | output | 4 | Applied oversampling code |
| cfg_twox | output | 1 | Applied double-speed flag |

## Verification
The bench builds the block with `CONV_CYCLES` = 24 and the default 24-bit result with 5 sub-LSBs. This keeps the frame at its full 32 bits while making each conversion short. Many complete conversions, full frames, early aborts and command captures therefore fit in one run. At this count the exact conversion length after reset, after `FRAME_DONE` and after `HOST_ABORT` can be counted directly. A short counter also lets the bench change `conv_data` between `CONV_DONE` and the read-out, which checks that the latched word is the one sent.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;

    typedef enum logic [1:0] {
        ST_CONVERT = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_OUTPUT  = 2'd2
    } adc_state_e;

    // length of the host command captured at the head of each frame
    localparam int CMD_BITS = 12;

    typedef struct packed {
        logic       sgl;
        logic [2:0] addr;
        logic [3:0] osr;
        logic       twox;
    } adc_cfg_t;

    // differential pair 0/1, oversampling code 3 (256), normal speed
    localparam adc_cfg_t CFG_RESET = '{sgl: 1'b0, addr: 3'd0, osr: 4'd3, twox: 1'b0};

endpackage

// File: rtl/adc_if_edges.sv
module adc_if_edges (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);

    logic sck_q;
    logic cs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // serial clock edges count only while the block is selected
    assign sck_rise = sck & ~sck_q & ~cs_n;
    assign sck_fall = ~sck & sck_q & ~cs_n;
    assign cs_rise  = cs_n & ~cs_q;

endmodule

// File: rtl/adc_if_conv_timer.sv
module adc_if_conv_timer #(
    parameter int CONV_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || done) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_if_frame.sv
module adc_if_frame
    import adc_if_pkg::*;
#(
    parameter int RES_BITS = 24,
    parameter int SUB_BITS = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [RES_BITS+SUB_BITS:0]   conv_data,
    input  logic                         shift,
    input  logic                         capture,
    input  logic                         sdi,
    output logic                         frame_bit,
    output logic                         last_bit,
    output logic                         cmd_ok,
    output adc_cfg_t                     cmd_cfg
);

    localparam int DATA_W    = RES_BITS + SUB_BITS + 1;
    localparam int FRAME_W   = DATA_W + 2;
    localparam int IDX_W     = $clog2(FRAME_W);
    localparam int CMD_CNT_W = $clog2(CMD_BITS + 1);
    localparam int EN_POS    = CMD_BITS - 3;

    logic [FRAME_W-1:0]   frame_q;
    logic [IDX_W-1:0]     idx_q;
    logic [CMD_BITS-1:0]  cmd_q;
    logic [CMD_CNT_W-1:0] cmd_cnt_q;

    // outgoing frame: latched at the end of conversion, read by pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_q <= '0;
            idx_q   <= IDX_W'(FRAME_W - 1);
        end else if (load) begin
            frame_q <= {2'b00, conv_data};
            idx_q   <= IDX_W'(FRAME_W - 1);
        end else if (shift && (idx_q != '0)) begin
            idx_q   <= idx_q - 1'b1;
        end
    end

    // incoming command: first CMD_BITS rising edges of the frame
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q     <= '0;
            cmd_cnt_q <= '0;
        end else if (load) begin
            cmd_q     <= '0;
            cmd_cnt_q <= '0;
        end else if (capture && (cmd_cnt_q < CMD_CNT_W'(CMD_BITS))) begin
            cmd_q     <= {cmd_q[CMD_BITS-2:0], sdi};
            cmd_cnt_q <= cmd_cnt_q + 1'b1;
        end
    end

    assign frame_bit    = frame_q[idx_q];
    assign last_bit     = (idx_q == '0);
    assign cmd_ok       = (cmd_cnt_q == CMD_CNT_W'(CMD_BITS)) && cmd_q[EN_POS];
    assign cmd_cfg.sgl  = cmd_q[8];
    assign cmd_cfg.addr = cmd_q[7:5];
    assign cmd_cfg.osr  = cmd_q[4:1];
    assign cmd_cfg.twox = cmd_q[0];

endmodule

// File: rtl/adc_if.sv
module adc_if
    import adc_if_pkg::*;
#(
    parameter int CONV_CYCLES = 4096,
    parameter int RES_BITS    = 24,
    parameter int SUB_BITS    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cs_n,
    input  logic                        sck,
    input  logic                        sdi,
    input  logic [RES_BITS+SUB_BITS:0]  conv_data,
    output logic                        sdo,
    output logic                        sdo_oe,
    output logic                        cfg_sgl,
    output logic [2:0]                  cfg_addr,
    output logic [3:0]                  cfg_osr,
    output logic                        cfg_twox
);

    adc_state_e state_q;
    adc_state_e state_d;

    logic     sck_rise;
    logic     sck_fall;
    logic     cs_rise;
    logic     conv_done;
    logic     conv_run;
    logic     frame_shift;
    logic     cmd_capture;
    logic     frame_end;
    logic     frame_bit;
    logic     last_bit;
    logic     cmd_ok;
    adc_cfg_t cmd_cfg;
    adc_cfg_t cfg_q;

    adc_if_edges u_edges (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sck      (sck),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    adc_if_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (conv_run),
        .done  (conv_done)
    );

    adc_if_frame #(
        .RES_BITS (RES_BITS),
        .SUB_BITS (SUB_BITS)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (conv_done),
        .conv_data (conv_data),
        .shift     (frame_shift),
        .capture   (cmd_capture),
        .sdi       (sdi),
        .frame_bit (frame_bit),
        .last_bit  (last_bit),
        .cmd_ok    (cmd_ok),
        .cmd_cfg   (cmd_cfg)
    );

    // next state: CONV_DONE, HOST_CLOCK, FRAME_DONE, HOST_ABORT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CONVERT: if (conv_done)                       state_d = ST_SLEEP;
            ST_SLEEP:   if (sck_rise)                        state_d = ST_OUTPUT;
            ST_OUTPUT:  if (cs_rise || (sck_fall && last_bit)) state_d = ST_CONVERT;
            default:                                         state_d = ST_CONVERT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CONVERT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs and datapath controls
    always_comb begin
        conv_run    = 1'b0;
        frame_shift = 1'b0;
        cmd_capture = 1'b0;
        sdo         = 1'b1;
        unique case (state_q)
            ST_CONVERT: begin
                conv_run = 1'b1;
                sdo      = 1'b1;
            end
            ST_SLEEP: begin
                cmd_capture = sck_rise;
                sdo         = 1'b0;
            end
            ST_OUTPUT: begin
                cmd_capture = sck_rise;
                frame_shift = sck_fall && !cs_rise;
                sdo         = frame_bit;
            end
            default: begin
                sdo = 1'b1;
            end
        endcase
        frame_end = (state_q == ST_OUTPUT) && (state_d == ST_CONVERT);
        sdo_oe    = !cs_n;
    end

    // configuration takes effect for the conversion that starts now
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (frame_end && cmd_ok) begin
            cfg_q <= cmd_cfg;
        end
    end

    assign cfg_sgl  = cfg_q.sgl;
    assign cfg_addr = cfg_q.addr;
    assign cfg_osr  = cfg_q.osr;
    assign cfg_twox = cfg_q.twox;

endmodule

// File: rtl/adc_if_chk.sv
module adc_if_chk
    import adc_if_pkg::*;
#(
    parameter int CONV_CYCLES = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sdo,
    input  adc_state_e state,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       cs_rise,
    input  adc_cfg_t   cfg
);

    logic [31:0] conv_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_cnt <= '0;
        end else if (state == ST_CONVERT) begin
            conv_cnt <= conv_cnt + 1'b1;
        end else begin
            conv_cnt <= '0;
        end
    end

    AST_DESELECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && cs_n) |=> (state == ST_SLEEP)); // R2

    AST_SLEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && !sck_rise) |=> (state == ST_SLEEP)); // R4

    AST_CONV_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SLEEP && $past(state) == ST_CONVERT) |-> ($past(conv_cnt) == CONV_CYCLES - 1)); // R3

    AST_CONV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT) |-> (conv_cnt < CONV_CYCLES)); // R3

    AST_SDO_FALL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OUTPUT && $past(state) == ST_OUTPUT && !$past(sck_fall)) |-> $stable(sdo)); // R6

    AST_FRAME_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONVERT && $past(state) == ST_OUTPUT) |-> ($past(cs_rise) || $past(sck_fall))); // R7 R8

    AST_CFG_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> ($past(state) == ST_OUTPUT && state == ST_CONVERT)); // R9

endmodule

bind adc_if adc_if_chk #(
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .sdo      (sdo),
    .state    (state_q),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .cs_rise  (cs_rise),
    .cfg      (cfg_q)
);

// File: tb/adc_if_tb.sv
module adc_if_tb;

    localparam int N = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        sdi = 1'b0;
    logic [29:0] conv_data = '0;
    logic        sdo;
    logic        sdo_oe;
    logic        cfg_sgl;
    logic [2:0]  cfg_addr;
    logic [3:0]  cfg_osr;
    logic        cfg_twox;

    always #2 clk = ~clk;

    adc_if #(.CONV_CYCLES(N), .RES_BITS(24), .SUB_BITS(5)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .conv_data(conv_data), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_sgl(cfg_sgl), .cfg_addr(cfg_addr), .cfg_osr(cfg_osr), .cfg_twox(cfg_twox)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] cfg_now();
        return {cfg_sgl, cfg_addr, cfg_osr, cfg_twox};
    endfunction

    // ---------------- behavioural reference model ----------------
    int          m_state;   // 0 converting, 1 waiting, 2 sending
    int          m_cnt;
    int          m_bit;
    logic [31:0] m_frame;
    bit          m_q[$];
    logic [8:0]  m_cfg;
    logic        p_sck;
    logic        p_cs;

    task automatic end_frame();
        if (m_q.size() >= 12 && m_q[2])
            m_cfg = {m_q[3], m_q[4], m_q[5], m_q[6], m_q[7], m_q[8], m_q[9], m_q[10], m_q[11]};
        m_state = 0;
        m_cnt   = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_bit = 31; m_frame = '0;
            m_q.delete(); m_cfg = 9'b0_000_0011_0;
            p_sck = 1'b0; p_cs = 1'b1;
        end else begin
            bit rise, fall, csr;
            rise = sck && !p_sck && !cs_n;
            fall = !sck && p_sck && !cs_n;
            csr  = cs_n && !p_cs;
            case (m_state)
                0: begin
                    m_cnt++;
                    if (m_cnt == N) begin
                        m_frame = {2'b00, conv_data};
                        m_bit = 31;
                        m_q.delete();
                        m_state = 1;
                    end
                end
                1: if (rise) begin
                    m_state = 2;
                    m_q.push_back(sdi);
                end
                default: begin
                    if (csr) end_frame();
                    else if (rise) begin
                        if (m_q.size() < 12) m_q.push_back(sdi);
                    end else if (fall) begin
                        if (m_bit == 0) end_frame();
                        else m_bit--;
                    end
                end
            endcase
            p_sck = sck;
            p_cs  = cs_n;
        end
        #1;
        if (rst_n && !done_flag) begin
            logic exp_sdo;
            string req;
            check(sdo_oe == !cs_n, "R2 sdo_oe", 32'(sdo_oe), 32'(!cs_n));
            if (!cs_n) begin
                exp_sdo = (m_state == 0) ? 1'b1 : (m_state == 1) ? 1'b0 : m_frame[m_bit];
                req = (m_state == 0) ? "R3 eoc high" : (m_state == 1) ? "R4 sleep eoc low" : "R6 frame bit";
                check(sdo == exp_sdo, req, 32'(sdo), 32'(exp_sdo));
            end
            check(cfg_now() == m_cfg, "R9 cfg track", 32'(cfg_now()), 32'(m_cfg));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic sck_cycle(input logic b);
        sdi = b;
        sck = 1'b1;
        @(negedge clk); @(negedge clk);
        sck = 1'b0;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic read_frame(input logic [11:0] cmd, input int nbits, output logic [31:0] got);
        got = '0;
        for (int k = 0; k < nbits; k++) begin
            got[31-k] = sdo;
            sck_cycle((k < 12) ? cmd[11-k] : 1'b0);
        end
    endtask

    task automatic count_eoc(output int cnt);
        cnt = 0;
        while (sdo === 1'b1) begin
            cnt++;
            @(negedge clk);
        end
    endtask

    task automatic wait_sleep();
        while (sdo !== 1'b0) @(negedge clk);
    endtask

    // ---------------- directed sequence ----------------
    localparam logic [29:0] DATA_A = 30'h3456_789A;
    localparam logic [29:0] DATA_B = 30'h2000_0000;
    localparam logic [29:0] DATA_C = 30'h0FFF_FFE0;
    localparam logic [29:0] DATA_D = 30'h3FFF_FFFF;

    initial begin
        logic [31:0] got;
        int cnt;
        conv_data = DATA_A;
        repeat (4) @(negedge clk);
        check(cfg_now() == 9'b0_000_0011_0, "R1 reset cfg", 32'(cfg_now()), 32'h006);
        rst_n = 1'b1;
        cs_n  = 1'b0;
        count_eoc(cnt);
        check(cnt == N, "R3 first conversion length", cnt, N);

        // deselected: output off, clock ignored
        cs_n = 1'b1;
        @(negedge clk);
        check(sdo_oe == 1'b0, "R2 hi-z while deselected", 32'(sdo_oe), 0);
        repeat (3) sck_cycle(1'b1);
        cs_n = 1'b0;
        @(negedge clk);
        check(sdo == 1'b0, "R2 R4 still waiting after ignored clocks", 32'(sdo), 0);
        conv_data = DATA_B;

        read_frame(12'b1011_1010_1101, 32, got);
        check(got == {2'b00, DATA_A}, "R5 R11 frame A", got, {2'b00, DATA_A});
        check(sdo == 1'b1, "R7 sdo high after 32nd fall", 32'(sdo), 1);
        check(cfg_now() == 9'b1_101_0110_1, "R9 cfg applied", 32'(cfg_now()), 32'h1AD);
        count_eoc(cnt);
        check(cnt == N - 1, "R7 next conversion length", cnt, N - 1);

        // enable bit clear
        conv_data = DATA_C;
        read_frame(12'b1000_0110_0100, 32, got);
        check(got == {2'b00, DATA_B}, "R5 frame B", got, {2'b00, DATA_B});
        check(cfg_now() == 9'b1_101_0110_1, "R10 enable clear keeps cfg", 32'(cfg_now()), 32'h1AD);
        count_eoc(cnt);

        // abort after 8 bits
        read_frame(12'b1010_0101_1110, 8, got);
        check(got[31:24] == {2'b00, DATA_C}[31:24], "R6 partial frame C", 32'(got[31:24]), 32'({2'b00, DATA_C}[31:24]));
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        check(cfg_now() == 9'b1_101_0110_1, "R10 short command keeps cfg", 32'(cfg_now()), 32'h1AD);
        count_eoc(cnt);
        check(cnt == N, "R8 conversion after abort", cnt, N);

        // abort after 14 bits, command complete
        read_frame(12'b1010_0111_0000, 14, got);
        check(got[31:18] == {2'b00, DATA_C}[31:18], "R6 partial frame C again", 32'(got[31:18]), 32'({2'b00, DATA_C}[31:18]));
        cs_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b0;
        check(cfg_now() == 9'b0_011_1000_0, "R9 cfg applied on abort", 32'(cfg_now()), 32'h070);
        check(sdo == 1'b1, "R8 eoc high after abort", 32'(sdo), 1);
        conv_data = DATA_D;
        wait_sleep();
        conv_data = DATA_A;
        read_frame(12'b0, 32, got);
        check(got == {2'b00, DATA_D}, "R5 R11 frame D", got, {2'b00, DATA_D});
        check(cfg_now() == 9'b0_011_1000_0, "R10 empty command keeps cfg", 32'(cfg_now()), 32'h070);
        repeat (4) @(negedge clk);

        done_flag = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule